// File: doc/BRIEF.md
# Two-way write-through cache controller with selectable victim policy

This block sits between a processor's word-wide load/store port and a slower lower-level memory. It holds 16 KB of data in 64-byte lines, organised as two ways per set, over an 18-bit byte address space. Hits are answered from the local data array. Misses refill the whole line from the lower level, one 32-bit word per handshake beat, and then serve the held request.

Every store is sent on to the lower level (write-through). A cached copy of the word is updated as well when the line is present. Two configuration inputs can be changed between requests. The first picks how a full set chooses its victim: a per-set least-recently-used bit, or a bit taken from a free-running 16-bit LFSR. The second picks whether a store that misses first pulls the line in (write-allocate) or only goes to memory. A `WAYS` parameter of 1 turns the same code into a direct-mapped cache with 256 sets.

The processor raises `cpu_req` with address, direction and data, and holds all four stable until `cpu_done` pulses. The lower-level port works the same way: `mem_req` is held with its address until `mem_ack` is seen for one cycle.

Top module: `wt2_cache`

## Requirements
- R1: After reset no line is valid. `cpu_done` and `mem_req` are low while no request is pending, and the first read of any address is a miss that refills a line.
- R2: Byte address bits [5:2] select the word, bits [12:6] select one of 128 sets and bits [17:13] form the tag. Two addresses 8192 bytes apart share a set, and both lines can be resident at once, one in each way.
- R3: A read hit raises `cpu_done` in the cycle after the first clock edge that sees the request, with the cached word on `cpu_rdata`. It makes no lower-level access.
- R4: A read miss issues exactly 16 lower-level reads. They start at the line base (address bits [5:0] zero) and step up by 4. `cpu_done` follows the last beat, carrying the requested word.
- R5: With `cfg_rand_victim`=0, a miss to a set whose two ways are valid replaces the way used least recently. Both hits and fills count as use.
- R6: With `cfg_rand_victim`=1, the victim for a full set comes from an LFSR bit that advances every cycle. Over repeated full-set misses, both ways get replaced.
- R7: A write hit makes exactly one lower-level write with the word-aligned address and the write data, and updates the cached word. A later read of that word hits and returns the new data.
- R8: A write miss with `cfg_write_alloc`=1 first refills the line with 16 reads and then makes one lower-level write. A later read of that word hits and returns the written data.
- R9: A write miss with `cfg_write_alloc`=0 makes one lower-level write and no lower-level reads. A later read of that address misses.
- R10: A miss fills an invalid way in its set before any valid way is replaced, in either victim mode.
- R11: `cpu_done` is a single-cycle pulse, and a request held until `cpu_done` is served exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_rand_victim | input | 1 | 1: pseudo-random victim, 0: least-recently-used victim |
| cfg_write_alloc | input | 1 | 1: a write miss refills the line first |
| cpu_req | input | 1 | Request valid, held until `cpu_done` |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 18 | Byte address of the request (bits [1:0] ignored) |
| cpu_wdata | input | 32 | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` |
| mem_req | output | 1 | Lower-level access request, held until `mem_ack` |
| mem_we | output | 1 | 1 for a lower-level write |
| mem_addr | output | 18 | Word-aligned lower-level byte address |
| mem_wdata | output | 32 | Lower-level write data |
| mem_ack | input | 1 | One-cycle completion of the lower-level beat |
| mem_rdata | input | 32 | Lower-level read data, valid with `mem_ack` |

## Verification
A corrupt tag or valid bit shows up on the very next access to that set. The access either takes a 16-beat refill it should not, or returns in one cycle with the wrong word, so each hit/miss check compares both the beat count and the data. A wrong replacement bit stays hidden until the set is full and a third line arrives. It then shows as an extra refill when the line that should have survived is read back, which is why the LRU and random scenarios read both earlier lines after each eviction. A slip in the refill address counter shows during the refill itself, as a broken ascending address sequence on `mem_addr`.

// File: rtl/wt2_cache_pkg.sv
package wt2_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WTHRU = 2'd2,
    ST_DONE  = 2'd3
  } ctl_state_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  // Fibonacci step for x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [15:0] lfsr_next(input logic [15:0] cur);
    return {cur[14:0], cur[15] ^ cur[13] ^ cur[12] ^ cur[10]};
  endfunction

endpackage

// File: rtl/wt2_tag_store.sv
module wt2_tag_store #(
  parameter int WAYS  = 2,
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  parameter int TAG_W = 5,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAYS-1:0]  valid_vec,
  output logic [WAY_W-1:0] lru_way,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] touch_idx
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  valid_d;
    logic             sel;

    assign sel = fill_en && (fill_way == WAY_W'(w));

    always_comb begin
      valid_d = valid_q;
      if (sel) valid_d[fill_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= '0;
      else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (sel) tag_q[fill_idx] <= fill_tag;
    end

    assign valid_vec[w] = valid_q[lk_idx];
    assign hit_vec[w]   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  end

  if (WAYS == 2) begin : g_lru
    logic [SETS-1:0] lru_q;
    logic [SETS-1:0] lru_d;

    always_comb begin
      lru_d = lru_q;
      if (touch_en) lru_d[touch_idx] = ~touch_way[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lru_q <= '0;
      else        lru_q <= lru_d;
    end

    assign lru_way = lru_q[lk_idx];

    // R5: the way just used is never left marked as least recently used
    a_r5_lru_points_away: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> (lru_q[$past(touch_idx)] != $past(touch_way[0])));
  end else begin : g_nolru
    logic unused_touch;
    assign unused_touch = touch_en ^ (^touch_way) ^ (^touch_idx);
    assign lru_way = '0;
  end

  // R2: a line is never resident in two ways of the same set
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/wt2_data_store.sv
module wt2_data_store #(
  parameter int IDX_W  = 7,
  parameter int WSEL_W = 4,
  parameter int WAY_W  = 1,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [WAY_W-1:0]  w_way,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [WSEL_W-1:0] w_wsel,
  input  logic [DATA_W-1:0] w_data,
  input  logic [WAY_W-1:0]  r_way,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic [WSEL_W-1:0] r_wsel,
  output logic [DATA_W-1:0] r_data
);

  localparam int LOC_W = WAY_W + IDX_W + WSEL_W;
  localparam int DEPTH = 1 << LOC_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [LOC_W-1:0]  w_loc;
  logic [LOC_W-1:0]  r_loc;

  assign w_loc  = {w_way, w_idx, w_wsel};
  assign r_loc  = {r_way, r_idx, r_wsel};
  assign r_data = mem_q[r_loc];

  always_ff @(posedge clk) begin
    if (we) mem_q[w_loc] <= w_data;
  end

endmodule

// File: rtl/wt2_victim.sv
module wt2_victim
  import wt2_cache_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rand_mode,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic [WAY_W-1:0] lru_way,
  output logic [WAY_W-1:0] victim
);

  if (WAYS == 2) begin : g_two
    logic [15:0] lfsr_q;
    logic [15:0] lfsr_d;

    assign lfsr_d = lfsr_next(lfsr_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lfsr_q <= LFSR_SEED;
      else        lfsr_q <= lfsr_d;
    end

    always_comb begin
      if (!valid_vec[0])      victim = 1'b0;
      else if (!valid_vec[1]) victim = 1'b1;
      else if (rand_mode)     victim = lfsr_q[0];
      else                    victim = lru_way;
    end

    // R6: the random source never locks up at zero
    a_r6_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != 16'h0000);
  end else begin : g_one
    logic unused_sel;
    assign unused_sel = rand_mode ^ (^valid_vec) ^ (^lru_way) ^ clk ^ rst_n;
    assign victim = '0;
  end

endmodule

// File: rtl/wt2_cache.sv
module wt2_cache
  import wt2_cache_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int CACHE_BYTES = 16384,
  parameter int LINE_BYTES  = 64,
  parameter int WORD_BYTES  = 4,
  parameter int WAYS        = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_rand_victim,
  input  logic                      cfg_write_alloc,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [8*WORD_BYTES-1:0]   cpu_wdata,
  output logic                      cpu_done,
  output logic [8*WORD_BYTES-1:0]   cpu_rdata,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [8*WORD_BYTES-1:0]   mem_wdata,
  input  logic                      mem_ack,
  input  logic [8*WORD_BYTES-1:0]   mem_rdata
);

  localparam int DATA_W = 8 * WORD_BYTES;
  localparam int WPL    = LINE_BYTES / WORD_BYTES;
  localparam int BSEL_W = $clog2(WORD_BYTES);
  localparam int WSEL_W = $clog2(WPL);
  localparam int OFF_W  = BSEL_W + WSEL_W;
  localparam int SETS   = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WPL - 1);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // request fields
  logic [WSEL_W-1:0] req_wsel;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              unused_bsel;

  assign req_wsel    = cpu_addr[OFF_W-1:BSEL_W];
  assign req_idx     = cpu_addr[OFF_W+IDX_W-1:OFF_W];
  assign req_tag     = cpu_addr[ADDR_W-1:OFF_W+IDX_W];
  assign unused_bsel = ^cpu_addr[BSEL_W-1:0];

  // state
  ctl_state_e        state_q, state_d;
  logic [WSEL_W-1:0] beat_q, beat_d;
  logic [WAY_W-1:0]  fill_way_q, fill_way_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  // lookup and array controls
  logic [WAYS-1:0]   hit_vec, valid_vec;
  logic [WAY_W-1:0]  lru_way, victim, hit_way;
  logic              hit_any;
  logic              fill_en, touch_en;
  logic [WAY_W-1:0]  touch_way;
  logic              d_we;
  logic [WAY_W-1:0]  d_way;
  logic [WSEL_W-1:0] d_wsel;
  logic [DATA_W-1:0] d_data, r_data;

  assign hit_any = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  wt2_tag_store #(
    .WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lk_idx    (req_idx),
    .lk_tag    (req_tag),
    .hit_vec   (hit_vec),
    .valid_vec (valid_vec),
    .lru_way   (lru_way),
    .fill_en   (fill_en),
    .fill_way  (fill_way_q),
    .fill_idx  (req_idx),
    .fill_tag  (req_tag),
    .touch_en  (touch_en),
    .touch_way (touch_way),
    .touch_idx (req_idx)
  );

  wt2_data_store #(
    .IDX_W(IDX_W), .WSEL_W(WSEL_W), .WAY_W(WAY_W), .DATA_W(DATA_W)
  ) u_data (
    .clk    (clk),
    .we     (d_we),
    .w_way  (d_way),
    .w_idx  (req_idx),
    .w_wsel (d_wsel),
    .w_data (d_data),
    .r_way  (hit_way),
    .r_idx  (req_idx),
    .r_wsel (req_wsel),
    .r_data (r_data)
  );

  wt2_victim #(
    .WAYS(WAYS), .WAY_W(WAY_W)
  ) u_victim (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rand_mode (cfg_rand_victim),
    .valid_vec (valid_vec),
    .lru_way   (lru_way),
    .victim    (victim)
  );

  // next state
  always_comb begin
    state_d    = state_q;
    beat_d     = beat_q;
    fill_way_d = fill_way_q;
    rdata_d    = rdata_q;
    fill_en    = 1'b0;
    touch_en   = 1'b0;
    touch_way  = hit_way;
    d_we       = 1'b0;
    d_way      = hit_way;
    d_wsel     = req_wsel;
    d_data     = cpu_wdata;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (hit_any) begin
            touch_en = 1'b1;
            if (cpu_we) begin
              d_we    = 1'b1;
              state_d = ST_WTHRU;
            end else begin
              rdata_d = r_data;
              state_d = ST_DONE;
            end
          end else if (!cpu_we || cfg_write_alloc) begin
            fill_way_d = victim;
            beat_d     = '0;
            state_d    = ST_FILL;
          end else begin
            state_d = ST_WTHRU;
          end
        end
      end
      ST_FILL: begin
        d_way  = fill_way_q;
        d_wsel = beat_q;
        d_data = mem_rdata;
        if (mem_ack) begin
          d_we = 1'b1;
          if (beat_q == LAST_BEAT) begin
            fill_en   = 1'b1;
            touch_en  = 1'b1;
            touch_way = fill_way_q;
            state_d   = ST_IDLE;   // replay the held request as a hit
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      ST_WTHRU: begin
        if (mem_ack) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= ST_IDLE;
      beat_q     <= '0;
      fill_way_q <= '0;
      rdata_q    <= '0;
    end else begin
      state_q    <= state_d;
      beat_q     <= beat_d;
      fill_way_q <= fill_way_d;
      rdata_q    <= rdata_d;
    end
  end

  // outputs
  assign cpu_done  = (state_q == ST_DONE);
  assign cpu_rdata = rdata_q;
  assign mem_req   = (state_q == ST_FILL) || (state_q == ST_WTHRU);
  assign mem_we    = (state_q == ST_WTHRU);
  assign mem_wdata = cpu_wdata;
  assign mem_addr  = (state_q == ST_FILL) ? {req_tag, req_idx, beat_q, BSEL_W'(0)}
                                          : {cpu_addr[ADDR_W-1:BSEL_W], BSEL_W'(0)};

  // R4: refill beats walk the line in ascending word order
  a_r4_fill_ascending: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_FILL && mem_ack && beat_q != LAST_BEAT)
      |=> (mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)));

  // R9: without allocation a store never starts a refill
  a_r9_no_alloc_fill: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_IDLE && cpu_req && cpu_we && !cfg_write_alloc)
      |=> (state_q != ST_FILL));

  // R3: a load hit completes next cycle with no lower-level access
  a_r3_hit_one_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_IDLE && cpu_req && !cpu_we && hit_any)
      |=> (cpu_done && !mem_req));

  // R7: an acknowledged write-through completes the store
  a_r7_store_completes: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_WTHRU && mem_ack) |=> cpu_done);

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_done |=> !cpu_done);

endmodule

// File: tb/tb_wt2_cache.sv
module tb_wt2_cache;

  logic        clk;
  logic        rst_n;
  logic        cfg_rand_victim, cfg_write_alloc;
  logic        cpu_req, cpu_we;
  logic [17:0] cpu_addr;
  logic [31:0] cpu_wdata;
  logic        cpu_done;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [17:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int nchk, nfail;
  int rd_cnt, wr_cnt;
  logic [17:0] rlog [64];
  logic [17:0] last_waddr;
  logic [31:0] last_wdata;
  logic [31:0] store [logic [17:0]];

  wt2_cache dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_rand_victim(cfg_rand_victim), .cfg_write_alloc(cfg_write_alloc),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input logic [17:0] a);
    return ({14'h0, a} * 32'h9E3779B1) ^ 32'h0F0F1234;
  endfunction

  function automatic logic [31:0] mem_word(input logic [17:0] a);
    if (store.exists(a)) return store[a];
    return pat(a);
  endfunction

  // address built from tag [17:13], set [12:6], word [5:2]
  function automatic logic [17:0] mk(input int tag, input int set, input int word);
    return {tag[4:0], set[6:0], word[3:0], 2'b00};
  endfunction

  // lower-level memory model: acknowledges one negedge after a request
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    rd_cnt = 0;
    wr_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          store[mem_addr] = mem_wdata;
          last_waddr = mem_addr;
          last_wdata = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = mem_word(mem_addr);
          rlog[rd_cnt % 64] = mem_addr;
          rd_cnt++;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [17:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc, output int nr, output int nw);
    int r0, w0;
    r0 = rd_cnt;
    w0 = wr_cnt;
    @(negedge clk);
    cpu_req = 1'b1;
    cpu_we = we;
    cpu_addr = a;
    cpu_wdata = wd;
    cyc = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end while (!cpu_done && cyc < 500);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    nr = rd_cnt - r0;
    nw = wr_cnt - w0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 done idle", 32'(cpu_done), 32'd0);
    chk("R1 mem_req idle", 32'(mem_req), 32'd0);
  endtask

  task automatic t_read_miss();
    logic [31:0] rd; int cyc, nr, nw, r0;
    logic [17:0] a;
    a = mk(1, 17, 6);
    r0 = rd_cnt;
    access(1'b0, a, '0, rd, cyc, nr, nw);
    chk("R1 first read refills", 32'(nr), 32'd16);
    chk("R4 miss data", rd, pat(a));
    chk("R4 no writes", 32'(nw), 32'd0);
    for (int k = 0; k < 16; k++)
      chk("R4 beat address", 32'(rlog[(r0 + k) % 64]), 32'(mk(1, 17, k)));
    chk("R4 done after last beat", 32'(cyc > 32), 32'd1);
  endtask

  task automatic t_read_hit();
    logic [31:0] rd; int cyc, nr, nw;
    access(1'b0, mk(1, 17, 9), '0, rd, cyc, nr, nw);
    chk("R3 hit latency", 32'(cyc), 32'd1);
    chk("R3 hit no reads", 32'(nr), 32'd0);
    chk("R3 hit data", rd, pat(mk(1, 17, 9)));
    @(negedge clk);
    chk("R11 done one cycle", 32'(cpu_done), 32'd0);
  endtask

  task automatic t_two_ways();
    logic [31:0] rd; int cyc, nr, nw;
    access(1'b0, mk(2, 17, 3), '0, rd, cyc, nr, nw);
    chk("R2 alias misses", 32'(nr), 32'd16);
    chk("R2 alias data", rd, pat(mk(2, 17, 3)));
    access(1'b0, mk(1, 17, 0), '0, rd, cyc, nr, nw);
    chk("R10 first line kept", 32'(nr), 32'd0);
    chk("R2 first line data", rd, pat(mk(1, 17, 0)));
    access(1'b0, mk(2, 17, 15), '0, rd, cyc, nr, nw);
    chk("R2 second line kept", 32'(nr), 32'd0);
  endtask

  task automatic t_lru();
    logic [31:0] rd; int cyc, nr, nw;
    cfg_rand_victim = 1'b0;
    access(1'b0, mk(1, 32, 0), '0, rd, cyc, nr, nw);
    access(1'b0, mk(2, 32, 0), '0, rd, cyc, nr, nw);
    access(1'b0, mk(1, 32, 1), '0, rd, cyc, nr, nw);
    chk("R5 touch hit", 32'(nr), 32'd0);
    access(1'b0, mk(3, 32, 0), '0, rd, cyc, nr, nw);
    chk("R5 third line refills", 32'(nr), 32'd16);
    access(1'b0, mk(1, 32, 2), '0, rd, cyc, nr, nw);
    chk("R5 recent line survives", 32'(nr), 32'd0);
    access(1'b0, mk(2, 32, 2), '0, rd, cyc, nr, nw);
    chk("R5 lru line evicted", 32'(nr), 32'd16);
    chk("R5 refetched data", rd, pat(mk(2, 32, 2)));
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int cyc, nr, nw;
    access(1'b1, mk(1, 17, 5) | 18'h3, 32'hCAFE_0005, rd, cyc, nr, nw);
    chk("R7 one write", 32'(nw), 32'd1);
    chk("R7 no reads", 32'(nr), 32'd0);
    chk("R7 write address", 32'(last_waddr), 32'(mk(1, 17, 5)));
    chk("R7 write data", last_wdata, 32'hCAFE_0005);
    access(1'b0, mk(1, 17, 5), '0, rd, cyc, nr, nw);
    chk("R7 read hits", 32'(nr), 32'd0);
    chk("R7 updated word", rd, 32'hCAFE_0005);
  endtask

  task automatic t_write_alloc();
    logic [31:0] rd; int cyc, nr, nw;
    cfg_write_alloc = 1'b1;
    access(1'b1, mk(4, 48, 7), 32'hA110_C007, rd, cyc, nr, nw);
    chk("R8 refill beats", 32'(nr), 32'd16);
    chk("R11 single write", 32'(nw), 32'd1);
    access(1'b0, mk(4, 48, 7), '0, rd, cyc, nr, nw);
    chk("R8 read hits", 32'(nr), 32'd0);
    chk("R8 written word", rd, 32'hA110_C007);
    access(1'b0, mk(4, 48, 8), '0, rd, cyc, nr, nw);
    chk("R8 neighbour word", rd, pat(mk(4, 48, 8)));
  endtask

  task automatic t_write_noalloc();
    logic [31:0] rd; int cyc, nr, nw;
    cfg_write_alloc = 1'b0;
    access(1'b1, mk(5, 49, 2), 32'h0A0A_5555, rd, cyc, nr, nw);
    chk("R9 no reads", 32'(nr), 32'd0);
    chk("R9 one write", 32'(nw), 32'd1);
    chk("R9 write data", last_wdata, 32'h0A0A_5555);
    access(1'b0, mk(5, 49, 2), '0, rd, cyc, nr, nw);
    chk("R9 later read misses", 32'(nr), 32'd16);
    chk("R9 data from memory", rd, 32'h0A0A_5555);
  endtask

  task automatic t_random();
    logic [31:0] rd; int cyc, nr, nw;
    int kept0;
    kept0 = 0;
    cfg_rand_victim = 1'b1;
    for (int s = 64; s < 80; s++) begin
      access(1'b0, mk(1, s, 0), '0, rd, cyc, nr, nw);
      access(1'b0, mk(2, s, 0), '0, rd, cyc, nr, nw);
      access(1'b0, mk(1, s, 1), '0, rd, cyc, nr, nw);
      chk("R10 invalid way used first", 32'(nr), 32'd0);
      access(1'b0, mk(3, s, 0), '0, rd, cyc, nr, nw);
      access(1'b0, mk(3, s, 4), '0, rd, cyc, nr, nw);
      chk("R6 new line resident", 32'(nr), 32'd0);
      access(1'b0, mk(1, s, 2), '0, rd, cyc, nr, nw);
      if (nr == 0) begin
        kept0++;
        access(1'b0, mk(2, s, 2), '0, rd, cyc, nr, nw);
        chk("R6 other line evicted", 32'(nr), 32'd16);
      end
    end
    chk("R6 both ways chosen", 32'(kept0 > 0 && kept0 < 16), 32'd1);
    cfg_rand_victim = 1'b0;
  endtask

  initial begin
    nchk = 0;
    nfail = 0;
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R11 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_rand_victim = 1'b0;
    cfg_write_alloc = 1'b0;
    cpu_req = 1'b0;
    cpu_we = 1'b0;
    cpu_addr = '0;
    cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_miss();
    t_read_hit();
    t_two_ways();
    t_lru();
    t_write_hit();
    t_write_alloc();
    t_write_noalloc();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule